// File: doc/BRIEF.md
# Burst Low-Address Sequencer

This block supplies the two least significant address bits for each beat of a four-beat burst in a pipelined synchronous memory. When either of two active-low address strobes is sampled low on a rising clock edge, the block captures the low bits of the presented address as the burst's start point and restarts its beat count at zero. After that, each edge with the active-low advance input low moves to the next beat. An edge with advance high suspends the burst and keeps the current beat and address. The upper address bits go to the array directly from the address register, so they are not handled here.

The beat order is chosen by a static order-select input. With order-select high, the block produces the interleaved order: the start bits XOR the beat number, so a start of 1 gives 1, 0, 3, 2. With order-select low, it produces the linear order: the start plus the beat, modulo four, so a start of 1 gives 1, 2, 3, 0. After four advances the sequence returns to its start point. A strobe in the middle of a burst restarts the sequence from a new base.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, and until the first strobe, `addr_lo` and `beat` are both 0.
- R2: If `strobe_p_n` or `strobe_c_n` is 0 at a rising edge, then after that edge `beat` is 0 and `addr_lo` equals the `base_lo` value sampled at that edge. This holds in either order mode.
- R3: If no strobe is low and `adv_n` is 0 at a rising edge, and a strobe has occurred since reset, then `beat` increases by one modulo 4 after that edge.
- R4: If no strobe is low and `adv_n` is 1 at a rising edge, then `beat` and the captured start point are unchanged after that edge.
- R5: With `order_sel` = 1 (interleaved), `addr_lo` equals the captured start bits XOR `beat`.
- R6: With `order_sel` = 0 (linear), `addr_lo` equals the captured start bits plus `beat`, modulo 4.
- R7: Four advances after a strobe, `beat` is 0 and `addr_lo` is back at the start bits.
- R8: A strobe takes priority over `adv_n`. A strobe during a burst restarts it from the new `base_lo`, even when `adv_n` is 0 at the same edge.
- R9: Before the first strobe after reset, `adv_n` = 0 has no effect, and `beat` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_p_n | input | 1 | Processor-side address strobe, active low |
| strobe_c_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Advance to the next beat, active low |
| order_sel | input | 1 | 1 selects the interleaved order, 0 selects the linear order |
| base_lo | input | 2 | Low address bits captured by a strobe |
| addr_lo | output | 2 | Generated low address bits for the current beat |
| beat | output | 2 | Beat number within the burst, from 0 to 3 |

## Verification
The bench runs a start of 1 through a full burst in both orders, so that the interleaved sequence 1,0,3,2 is told apart from the linear sequence 1,2,3,0. A design that swapped the orders, or added where it should XOR, would miss on the second beat. The wrap back to the start after four advances catches a counter that saturates instead of wrapping. Advancing before any strobe catches a design that counts from reset. A strobe together with a low advance checks that a new burst wins over an increment. Random cycles mix suspends, restarts from either strobe and changes of order.

// File: rtl/burst_pkg.sv
package burst_pkg;
    localparam int BURST_LO_W = 2;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } order_e;
endpackage

// File: rtl/burst_strobe_dec.sv
module burst_strobe_dec (
    input  logic strobe_p_n,
    input  logic strobe_c_n,
    input  logic adv_n,
    output logic load,
    output logic advance
);
    always_comb begin
        load    = ~strobe_p_n | ~strobe_c_n;
        advance = ~adv_n & ~load;
    end
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl #(
    parameter int LO_W = burst_pkg::BURST_LO_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            advance,
    input  logic [LO_W-1:0] base,
    output logic [LO_W-1:0] start,
    output logic [LO_W-1:0] beat
);
    typedef struct packed {
        logic [LO_W-1:0] start;
        logic [LO_W-1:0] beat;
        logic            active;
    } beat_st_t;

    beat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.start  = base;
            st_d.beat   = '0;
            st_d.active = 1'b1;
        end else if (advance && st_q.active) begin
            st_d.beat = st_q.beat + LO_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start = st_q.start;
    assign beat  = st_q.beat;
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
    parameter int LO_W = burst_pkg::BURST_LO_W
) (
    input  burst_pkg::order_e order,
    input  logic [LO_W-1:0]   start,
    input  logic [LO_W-1:0]   beat,
    output logic [LO_W-1:0]   addr
);
    logic [LO_W-1:0] xor_addr;
    logic [LO_W-1:0] sum_addr;

    for (genvar i = 0; i < LO_W; i++) begin : g_xor_bit
        assign xor_addr[i] = start[i] ^ beat[i];
    end

    always_comb begin
        sum_addr = start + beat;
        if (order == burst_pkg::ORDER_INTERLEAVED) begin
            addr = xor_addr;
        end else begin
            addr = sum_addr;
        end
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
    parameter int LO_W = burst_pkg::BURST_LO_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strobe_p_n,
    input  logic            strobe_c_n,
    input  logic            adv_n,
    input  logic            order_sel,
    input  logic [LO_W-1:0] base_lo,
    output logic [LO_W-1:0] addr_lo,
    output logic [LO_W-1:0] beat
);
    logic            load;
    logic            advance;
    logic [LO_W-1:0] start;
    burst_pkg::order_e order;

    assign order = burst_pkg::order_e'(order_sel);

    burst_strobe_dec u_dec (
        .strobe_p_n (strobe_p_n),
        .strobe_c_n (strobe_c_n),
        .adv_n      (adv_n),
        .load       (load),
        .advance    (advance)
    );

    burst_beat_ctrl #(.LO_W(LO_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .advance (advance),
        .base    (base_lo),
        .start   (start),
        .beat    (beat)
    );

    burst_order_map #(.LO_W(LO_W)) u_map (
        .order (order),
        .start (start),
        .beat  (beat),
        .addr  (addr_lo)
    );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int LO_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            strobe_p_n,
    input logic            strobe_c_n,
    input logic            adv_n,
    input logic            order_sel,
    input logic [LO_W-1:0] base_lo,
    input logic [LO_W-1:0] addr_lo,
    input logic [LO_W-1:0] beat
);
    logic            strobe;
    logic            seen_q;
    logic [LO_W-1:0] base_q;

    assign strobe = !strobe_p_n || !strobe_c_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            base_q <= '0;
        end else if (strobe) begin
            seen_q <= 1'b1;
            base_q <= base_lo;
        end
    end

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (beat == '0 && addr_lo == '0));

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (beat == '0 && addr_lo == $past(base_lo)));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !adv_n && seen_q) |=> beat == LO_W'($past(beat) + LO_W'(1)));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && adv_n) |=> $stable(beat));

    p_xor_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (order_sel && seen_q) |-> addr_lo == (base_q ^ beat));

    p_add_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!order_sel && seen_q) |-> addr_lo == LO_W'(base_q + beat));

    p_no_early_adv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_q && !strobe) |=> beat == '0);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.LO_W(LO_W)) u_chk (.*);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe_p_n = 1'b1;
    logic       strobe_c_n = 1'b1;
    logic       adv_n = 1'b1;
    logic       order_sel = 1'b1;
    logic [1:0] base_lo = 2'd0;
    logic [1:0] addr_lo;
    logic [1:0] beat;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [1:0] m_start = 2'd0;
    logic [1:0] m_beat = 2'd0;
    bit         m_active = 1'b0;

    always #10 clk = ~clk;

    burst_addr_gen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_p_n (strobe_p_n),
        .strobe_c_n (strobe_c_n),
        .adv_n      (adv_n),
        .order_sel  (order_sel),
        .base_lo    (base_lo),
        .addr_lo    (addr_lo),
        .beat       (beat)
    );

    function automatic logic [1:0] exp_addr(logic [1:0] s, logic [1:0] b, logic o);
        if (o) return s ^ b;
        return 2'(s + b);
    endfunction

    task automatic check(string tag);
        logic [1:0] ea;
        ea = exp_addr(m_start, m_beat, order_sel);
        checks++;
        if (addr_lo !== ea || beat !== m_beat) begin
            failures++;
            $display("FAIL %s: addr_lo=%0d beat=%0d expected addr_lo=%0d beat=%0d",
                     tag, addr_lo, beat, ea, m_beat);
        end
    endtask

    task automatic cyc(logic p, logic c, logic a, logic o, logic [1:0] b);
        strobe_p_n = p;
        strobe_c_n = c;
        adv_n      = a;
        order_sel  = o;
        base_lo    = b;
        @(posedge clk);
        if (!p || !c) begin
            m_start  = b;
            m_beat   = 2'd0;
            m_active = 1'b1;
        end else if (!a && m_active) begin
            m_beat = m_beat + 2'd1;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset");

        for (int i = 0; i < 3; i++) begin
            cyc(1, 1, 0, 1, 2'd2);
            check("R9 advance before strobe");
        end

        cyc(0, 1, 1, 1, 2'd1);
        check("R2 processor strobe load");
        for (int i = 0; i < 3; i++) begin
            cyc(1, 1, 0, 1, 2'd3);
            check("R5 interleaved beat");
        end
        cyc(1, 1, 0, 1, 2'd0);
        check("R7 interleaved wrap");

        cyc(1, 0, 1, 0, 2'd1);
        check("R2 controller strobe load");
        for (int i = 0; i < 3; i++) begin
            cyc(1, 1, 0, 0, 2'd2);
            check("R6 linear beat");
        end
        cyc(1, 1, 0, 0, 2'd2);
        check("R7 linear wrap");

        cyc(1, 1, 0, 0, 2'd0);
        for (int i = 0; i < 2; i++) begin
            cyc(1, 1, 1, 0, 2'd3);
            check("R4 suspend holds");
        end

        cyc(0, 1, 0, 1, 2'd3);
        check("R8 strobe beats advance");
        cyc(1, 0, 0, 0, 2'd2);
        check("R8 restart mid burst");

        for (int i = 0; i < 400; i++) begin
            logic p, c, a, o;
            string tag;
            p = ($urandom % 8) != 0;
            c = ($urandom % 8) != 0;
            a = $urandom % 2;
            o = ($urandom % 16) == 0 ? ~order_sel : order_sel;
            cyc(p, c, a, o, 2'($urandom));
            if (!p || !c) tag = "R2 random load";
            else if (a) tag = "R4 random hold";
            else tag = "R3 random step";
            check(tag);
            check(o ? "R5 random map" : "R6 random map");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule